// File: doc/BRIEF.md
# Base-Delta Cache Line Decompressor

This block turns a compressed cache line back into its full 64-byte form. The caller presents three things together with a valid strobe: a payload, a 4-bit state code, and a vector of per-element base-select flags. One clock later the block returns the rebuilt 512-bit line and a done strobe.

The state code selects one of several forms. A line can be all zeros. It can be one 8-byte value repeated. It can be stored raw. Or it can be one of six base/delta forms, in which every element is a small signed delta added either to zero or to a single stored base. The element that supplied the nonzero base carries no delta in the payload and is rebuilt from the base alone. Some codes mark that two copies of a narrow line are held in the array; they decode exactly like their single-copy twins. Codes with no assigned meaning raise an error flag.

Top module: `bd_line_decomp`

## Requirements
- R1: Timing and hold:
  - `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
  - A cycle without `in_valid` leaves `out_line` unchanged.
- R2: Code 0000 yields an all-zero line, whatever the payload and flags hold.
- R3: Code 0001 copies payload bytes 0..7 into each of the eight 8-byte elements of the line.
- R4: Code 1111 passes the 64 payload bytes to the line unchanged.
- R5: Each code below selects a base/delta form, given as element bytes E and delta bytes D:

  | Code | E | D |
  |------|---|---|
  | 0010 | 8 | 1 |
  | 0101 | 8 | 2 |
  | 1000 | 8 | 4 |
  | 1100 | 4 | 1 |
  | 0100 | 4 | 2 |
  | 1110 | 2 | 1 |

  Element i occupies line bits [i·8E +: 8E], and the line holds 64/E elements.
- R6: Payload layout for a base/delta form:
  - The base sits in payload bytes 0..E-1.
  - The stored deltas follow from byte E upward, D bytes each, in ascending element order.
  - Each delta is sign-extended to E bytes.
- R7: Flag bit i high means element i = base + delta, modulo 2^(8E). Flag bit i low means element i = delta. Flag bits at or above the element count have no effect.
- R8: The base source is the lowest-indexed element whose flag is high.
  - That element equals the base exactly and takes no delta slot.
  - Each later element uses the slot one below its own index.
  - When no flag is high, element i uses slot i.
- R9: Codes 0011, 0110, 0111 and 1101 give the same line as 0001, 0010, 0101 and 1100 respectively.
- R10: Codes 1001, 1010 and 1011 raise `out_err` together with `out_valid` and give a zero line. `out_err` is low after every other input and in every cycle without a result.
- R11: While `rst` is high and after it, before any input, `out_valid` and `out_err` are low and `out_line` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compressed line present this cycle |
| in_code | input | 4 | State code |
| in_payload | input | 512 | Compressed bytes, byte 0 in bits 7:0 |
| in_flags | input | 32 | Per-element base-select flags, bit i for element i |
| out_valid | output | 1 | Rebuilt line ready (done strobe) |
| out_line | output | 512 | Rebuilt 64-byte line |
| out_err | output | 1 | The code given was unassigned |

## Verification
The bench aims at the base source and its omitted delta:
- It places the first set flag at element 0, in the middle, at the last element, and nowhere at all.
- A design that forgot to skip the slot, or skipped it unconditionally, would shift every later element by one delta.

It also feeds the following, each of which catches a specific fault:
- Negative deltas and base sums that wrap. These catch zero-extension or a carry leaking into the next element.
- Stray flag bits above the element count. These catch a lane that reads beyond its elements.
- Duplicate-copy codes. These would surface as a wrong or error line if they were not folded onto their twins.
- Idle gaps between inputs. These expose a line that drifts instead of holding.

// File: rtl/bd_pkg.sv
`timescale 1ns/1ps
package bd_pkg;
  typedef enum logic [3:0] {
    F_ZERO, F_REP, F_RAW, F_B8D1, F_B8D2, F_B8D4, F_B4D1, F_B4D2, F_B2D1, F_BAD
  } form_e;

  localparam int NUM_LANES = 6;

  // lane order: b8d1 b8d2 b8d4 b4d1 b4d2 b2d1
  function automatic int lane_of(form_e f);
    case (f)
      F_B8D1:  return 0;
      F_B8D2:  return 1;
      F_B8D4:  return 2;
      F_B4D1:  return 3;
      F_B4D2:  return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int lane_eb(int g);
    case (g)
      0, 1, 2: return 8;
      3, 4:    return 4;
      default: return 2;
    endcase
  endfunction

  function automatic int lane_db(int g);
    case (g)
      1, 4:    return 2;
      2:       return 4;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/bd_code_decode.sv
`timescale 1ns/1ps
module bd_code_decode
  import bd_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic [CODE_W-1:0] code,
  output form_e             form
);
  // duplicated-copy codes fold onto their single-copy twins (R9)
  always_comb begin
    case (code)
      4'b0000:          form = F_ZERO;
      4'b0001, 4'b0011: form = F_REP;
      4'b1111:          form = F_RAW;
      4'b0010, 4'b0110: form = F_B8D1;
      4'b0101, 4'b0111: form = F_B8D2;
      4'b1000:          form = F_B8D4;
      4'b1100, 4'b1101: form = F_B4D1;
      4'b0100:          form = F_B4D2;
      4'b1110:          form = F_B2D1;
      default:          form = F_BAD;
    endcase
  end
endmodule

// File: rtl/bd_first_set.sv
`timescale 1ns/1ps
module bd_first_set #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  flags,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = N-1; k >= 0; k--) begin
      if (flags[k]) begin
        idx = IW'(k);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bd_lane.sv
`timescale 1ns/1ps
module bd_lane #(
  parameter int LINE_BYTES = 64,
  parameter int EB = 8,
  parameter int DB = 1,
  localparam int N  = LINE_BYTES / EB,
  localparam int IW = $clog2(N),
  localparam int LW = LINE_BYTES * 8
) (
  input  logic [LW-1:0] payload,
  input  logic [N-1:0]  flags,
  output logic [LW-1:0] line
);
  logic [IW-1:0]   src;
  logic            has_src;
  logic [EB*8-1:0] base;

  bd_first_set #(.N(N)) u_first (
    .flags (flags),
    .idx   (src),
    .any   (has_src)
  );

  assign base = payload[EB*8-1:0];

  always_comb begin
    line = '0;
    for (int i = 0; i < N; i++) begin
      int              slot;
      logic [DB*8-1:0] d;
      logic [EB*8-1:0] sx;
      slot = (has_src && i > int'(src)) ? i - 1 : i;
      d    = payload[(EB + slot*DB)*8 +: DB*8];
      sx   = {{((EB-DB)*8){d[DB*8-1]}}, d};
      if (has_src && i == int'(src))
        line[i*EB*8 +: EB*8] = base;
      else if (flags[i])
        line[i*EB*8 +: EB*8] = base + sx;
      else
        line[i*EB*8 +: EB*8] = sx;
    end
  end
endmodule

// File: rtl/bd_line_decomp.sv
`timescale 1ns/1ps
module bd_line_decomp
  import bd_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int CODE_W = 4,
  localparam int LW = LINE_BYTES * 8,
  localparam int FW = LINE_BYTES / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  input  logic [LW-1:0]     in_payload,
  input  logic [FW-1:0]     in_flags,
  output logic              out_valid,
  output logic [LW-1:0]     out_line,
  output logic              out_err
);
  form_e       form;
  logic [LW-1:0] lane_line [NUM_LANES];
  logic [LW-1:0] next_line;

  bd_code_decode #(.CODE_W(CODE_W)) u_dec (
    .code (in_code),
    .form (form)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int EB = lane_eb(g);
    localparam int DB = lane_db(g);
    bd_lane #(.LINE_BYTES(LINE_BYTES), .EB(EB), .DB(DB)) u_lane (
      .payload (in_payload),
      .flags   (in_flags[LINE_BYTES/EB-1:0]),
      .line    (lane_line[g])
    );
  end

  always_comb begin
    case (form)
      F_ZERO, F_BAD: next_line = '0;
      F_REP:         next_line = {(LINE_BYTES/8){in_payload[63:0]}};
      F_RAW:         next_line = in_payload;
      default:       next_line = lane_line[lane_of(form)];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_line  <= '0;
    end else begin
      out_valid <= in_valid;
      out_err   <= in_valid && (form == F_BAD);
      if (in_valid) out_line <= next_line;
    end
  end
endmodule

// File: rtl/bd_line_decomp_chk.sv
`timescale 1ns/1ps
module bd_line_decomp_chk #(
  parameter int LW = 512,
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [3:0]    in_code,
  input logic [LW-1:0] in_payload,
  input logic [FW-1:0] in_flags,
  input logic          out_valid,
  input logic [LW-1:0] out_line,
  input logic          out_err
);
  a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_line));
  a_r2_zero_line: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'b0000) |=> (out_line == '0));
  a_r3_repeat: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'b0001) |=> (out_line == {(LW/64){$past(in_payload[63:0])}}));
  a_r4_raw: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'b1111) |=> (out_line == $past(in_payload)));
  a_r10_err_line: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_valid && out_line == '0));
  a_r10_err_cause: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code[3] && !in_code[2] && (in_code[1:0] != 2'b00)) |=> out_err);
  a_r8_base_src0: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_code == 4'b0010 && in_flags[0]) |=> (out_line[63:0] == $past(in_payload[63:0])));
endmodule

bind bd_line_decomp bd_line_decomp_chk #(.LW(LW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_code    (in_code),
  .in_payload (in_payload),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_line   (out_line),
  .out_err    (out_err)
);

// File: tb/bd_line_decomp_tb.sv
`timescale 1ns/1ps
module bd_line_decomp_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   in_code;
  logic [511:0] in_payload;
  logic [31:0]  in_flags;
  logic         out_valid;
  logic [511:0] out_line;
  logic         out_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [511:0] exp_line;
  logic         exp_valid;
  logic         exp_err;
  string        exp_tag;

  always #2 clk = ~clk;

  bd_line_decomp u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_payload(in_payload), .in_flags(in_flags),
    .out_valid(out_valid), .out_line(out_line), .out_err(out_err)
  );

  function automatic logic [63:0] bmask(int n);
    return (n >= 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  // behavioural reference built from the requirement text
  function automatic void ref_model(input logic [3:0] c, input logic [511:0] p,
                                    input logic [31:0] f, output logic [511:0] ln,
                                    output logic er);
    int eb = 0, db = 0, n, src;
    logic [63:0] base, d, v;
    logic [511:0] t;
    ln = '0; er = 1'b0;
    case (c)
      4'b0000: ln = '0;
      4'b0001, 4'b0011: ln = {8{p[63:0]}};
      4'b1111: ln = p;
      4'b0010, 4'b0110: begin eb = 8; db = 1; end
      4'b0101, 4'b0111: begin eb = 8; db = 2; end
      4'b1000: begin eb = 8; db = 4; end
      4'b1100, 4'b1101: begin eb = 4; db = 1; end
      4'b0100: begin eb = 4; db = 2; end
      4'b1110: begin eb = 2; db = 1; end
      default: er = 1'b1;
    endcase
    if (eb != 0) begin
      n = 64 / eb;
      src = -1;
      for (int i = 0; i < n; i++) if (f[i] && src < 0) src = i;
      base = p[63:0] & bmask(eb);
      for (int i = 0; i < n; i++) begin
        if (i == src) v = base;
        else begin
          int slot;
          slot = (src >= 0 && i > src) ? i - 1 : i;
          t = p >> (8*(eb + slot*db));
          d = t[63:0] & bmask(db);
          if (d[db*8-1]) d = d | ~bmask(db);
          v = f[i] ? base + d : d;
        end
        v = v & bmask(eb);
        ln = ln | (512'(v) << (i*eb*8));
      end
    end
  endfunction

  task automatic check(string tag, bit ok, string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic compare_outputs();
    check(exp_tag, out_valid === exp_valid,
          $sformatf("out_valid actual %b expected %b", out_valid, exp_valid));
    check(exp_tag, out_err === exp_err,
          $sformatf("out_err actual %b expected %b", out_err, exp_err));
    check(exp_tag, out_line === exp_line,
          $sformatf("out_line actual %h expected %h", out_line, exp_line));
  endtask

  // one cycle: check last cycle's result, then drive the next input
  task automatic step(bit v, logic [3:0] c, logic [511:0] p, logic [31:0] f, string tag);
    logic [511:0] ln;
    logic er;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_code = c; in_payload = p; in_flags = f;
    exp_valid = v;
    if (v) begin
      ref_model(c, p, f, ln, er);
      exp_line = ln;
      exp_err  = er;
    end else exp_err = 1'b0;
    exp_tag = tag;
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] r;
    for (int k = 0; k < 16; k++) r[k*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    logic [511:0] pl;
    rst = 1'b1; in_valid = 0; in_code = 0; in_payload = '0; in_flags = '0;
    exp_valid = 0; exp_err = 0; exp_line = '0; exp_tag = "R11";
    repeat (3) @(negedge clk);
    compare_outputs();                          // R11 during reset
    rst = 1'b0;
    step(0, 4'h0, '0, '0, "R11");               // R11 after reset, idle

    pl = rnd512();
    step(1, 4'b0000, pl, '1, "R2");             // R2 nonzero payload ignored
    step(1, 4'b0001, pl, '0, "R3");             // R3
    step(1, 4'b1111, pl, '0, "R4");             // R4
    step(0, 4'b0000, '0, '0, "R1");             // R1 hold across idle
    step(0, 4'b1110, rnd512(), '1, "R1");

    // R5/R6: every base/delta form with no flags (pure deltas, slot = index)
    step(1, 4'b0010, pl, 32'h0, "R5");
    step(1, 4'b0101, pl, 32'h0, "R6");
    step(1, 4'b1000, pl, 32'h0, "R5");
    step(1, 4'b1100, pl, 32'h0, "R6");
    step(1, 4'b0100, pl, 32'h0, "R5");
    step(1, 4'b1110, pl, 32'h0, "R6");

    // R8: base source placement at first, middle, last element
    step(1, 4'b0010, pl, 32'h01, "R8");
    step(1, 4'b0010, pl, 32'h18, "R8");
    step(1, 4'b0010, pl, 32'h80, "R8");
    step(1, 4'b1110, pl, 32'h8000_0000, "R8");
    step(1, 4'b1100, pl, 32'h0000_0100, "R8");

    // R7: negative deltas and wrapping sums; flags above element count ignored
    pl = {{63{8'hFF}}, 8'h80};
    step(1, 4'b0010, pl, 32'hFE, "R7");
    pl = {{60{8'hF7}}, 32'hFFFF_FFF0};
    step(1, 4'b1100, pl, 32'hFFFF_0FF0, "R7");
    pl = rnd512();
    step(1, 4'b1000, pl, 32'hFFFF_FF05, "R7");
    step(1, 4'b0100, pl, 32'hFFFF_0000, "R7");

    // R9: duplicate-copy codes against their twins
    step(1, 4'b0011, pl, 32'h3, "R9");
    step(1, 4'b0110, pl, 32'h6, "R9");
    step(1, 4'b0111, pl, 32'h9, "R9");
    step(1, 4'b1101, pl, 32'hA, "R9");

    // R10: unassigned codes, then a good code clears the error
    step(1, 4'b1001, pl, '1, "R10");
    step(1, 4'b1010, pl, '0, "R10");
    step(1, 4'b1011, pl, '1, "R10");
    step(1, 4'b0001, pl, '0, "R10");

    // R1 plus random mix over all codes
    for (int k = 0; k < 400; k++) begin
      bit v;
      v = ($urandom % 4) != 0;
      step(v, 4'($urandom), rnd512(), $urandom, "R1");
    end
    step(0, 4'h0, '0, '0, "R1");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    done = 1;
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule